// File: doc/BRIEF.md
# Triggered Hit Frame Store

This block records a snapshot of a multi-channel digital front end every time a trigger strobe arrives. Each snapshot, called a frame, holds the 2-bit discriminator code of every channel, whether or not that channel fired. It also holds the bunch-crossing number at the trigger and an 8-bit header that carries the slot index. Frames go into an on-chip memory one after another, starting at slot 0. The memory can be inferred as block RAM.

When the last slot has been written, a full flag rises and further triggers are dropped. A readout controller then pulls the frames out in the order they were written. Each read strobe returns one frame. The read of the last stored frame empties the store, and acquisition can start again from slot 0. The bunch-crossing counter is internal. It counts every clock from reset and wraps at its width.

Top module: `hit_frame_store`

## Requirements
- R1: While reset is high and on the first cycle after it, `frame_cnt` is 0, `ram_full` is 0 and `rd_valid` is 0. The bunch-crossing counter restarts at 0.
- R2: A frame is laid out as {header, bunch-crossing number, codes}. Channel i's code sits at bits [2i+1:2i] (bits 127:0 by default). The bunch-crossing number sits at bits 151:128. The header sits at bits 159:152 and equals the slot index, zero-extended.
- R3: Every accepted trigger stores one frame holding all channels exactly as presented, including a frame in which every code is 0. Triggers on consecutive cycles store consecutive frames.
- R4: `ram_full` goes high on the cycle after the 128th frame is stored. While it is high, triggers are ignored and `frame_cnt` stays at 128.
- R5: `frame_cnt` rises by one on the cycle after each accepted trigger.
- R6: A read strobe with at least one stored frame gives `rd_valid` high and the next frame in write order on `rd_data` in the following cycle. A read strobe with no stored frame is ignored, and `rd_valid` stays low.
- R7: The cycle after the read of the last stored frame, `frame_cnt` is 0 and `ram_full` is 0. The next stored frame goes to slot 0.
- R8: A trigger is ignored once readout has begun and until it completes. It is also ignored in a cycle whose read strobe is accepted, because reads take priority.
- R9: The bunch-crossing counter rises by one every clock and wraps from all ones to 0. A frame records the value the counter holds on the trigger cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Trigger strobe, one frame per accepted cycle |
| disc | input | 128 | Discriminator codes, 2 bits per channel |
| rd_en | input | 1 | Read strobe from the readout controller |
| frame_cnt | output | 8 | Number of frames stored (0 to 128) |
| ram_full | output | 1 | All slots written; acquisition stops |
| rd_valid | output | 1 | `rd_data` holds a frame this cycle |
| rd_data | output | 160 | Frame read out |

## Verification
The hardest situations to reach from the ports are the full store and the wrap of the 24-bit bunch-crossing counter. The bench fills the store by holding the trigger high for 138 cycles, so the last ten triggers hit a full store. It then drains all 128 frames back to back, which drives the clear-on-last-read path. A wrap would take millions of cycles at full width. A second, small instance with a 3-bit counter and a 16-slot store therefore takes twelve consecutive triggers, so the counter wraps within the stored frames. Triggers that coincide with a read, or that arrive in mid-readout, are placed at exact cycles.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  localparam int unsigned DEF_NCH    = 64;
  localparam int unsigned DEF_CODE_W = 2;
  localparam int unsigned DEF_BX_W   = 24;
  localparam int unsigned DEF_HDR_W  = 8;
  localparam int unsigned DEF_DEPTH  = 128;
endpackage

// File: rtl/hfs_bx_counter.sv
module hfs_bx_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] bx
);
  always_ff @(posedge clk) begin
    if (rst) bx <= '0;
    else     bx <= bx + 1'b1;
  end

  // R9: one step per clock, wrapping modulo 2^W
  a_r9_bx_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> bx == W'($past(bx) + 1'b1));
endmodule

// File: rtl/hfs_frame_ram.sv
module hfs_frame_ram #(
  parameter int unsigned W     = 160,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  // R6: a read never targets the slot being written in the same cycle
  a_r6_no_collide: assert property (@(posedge clk)
    (we && re) |-> waddr != raddr);
endmodule

// File: rtl/hfs_ctrl.sv
module hfs_ctrl #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig,
  input  logic          rd_en,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] cnt_q,
  output logic          full_q,
  output logic          rd_valid_q
);
  logic [CW-1:0] rptr_q;
  logic          rd_take, wr_take, last_rd;

  always_comb begin
    rd_take = rd_en && (cnt_q != '0);
    wr_take = trig && !full_q && (rptr_q == '0) && !rd_take;
    last_rd = rd_take && (CW'(rptr_q + 1'b1) == cnt_q);
  end

  assign we    = wr_take;
  assign waddr = cnt_q[AW-1:0];
  assign re    = rd_take;
  assign raddr = rptr_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      rptr_q     <= '0;
      full_q     <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_take;
      if (last_rd) begin
        cnt_q  <= '0;
        rptr_q <= '0;
        full_q <= 1'b0;
      end else begin
        if (wr_take) cnt_q <= cnt_q + 1'b1;
        if (rd_take) rptr_q <= rptr_q + 1'b1;
        if (wr_take && cnt_q == CW'(DEPTH - 1)) full_q <= 1'b1;
      end
    end
  end

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  a_r4_full_freeze: assert property (@(posedge clk) disable iff (rst)
    (full_q && !rd_en) |=> cnt_q == $past(cnt_q));
  a_r5_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (trig && !full_q && rptr_q == '0 && !rd_en) |=> cnt_q == CW'($past(cnt_q) + 1'b1));
  a_r6_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cnt_q != '0) |=> rd_valid_q);
  a_r6_empty_read_ignored: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cnt_q == '0) |=> !rd_valid_q);
  a_r7_clear_on_last: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cnt_q != '0 && CW'(rptr_q + 1'b1) == cnt_q) |=> (cnt_q == '0 && !full_q));
  a_r8_no_write_in_readout: assert property (@(posedge clk) disable iff (rst)
    (rptr_q != '0) |-> !we);
endmodule

// File: rtl/hit_frame_store.sv
module hit_frame_store
  import hfs_pkg::*;
#(
  parameter int unsigned NCH    = DEF_NCH,
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned BX_W   = DEF_BX_W,
  parameter int unsigned HDR_W  = DEF_HDR_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned DISC_W  = NCH * CODE_W,
  localparam int unsigned FRAME_W = HDR_W + BX_W + DISC_W,
  localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig,
  input  logic [DISC_W-1:0]  disc,
  input  logic               rd_en,
  output logic [CW-1:0]      frame_cnt,
  output logic               ram_full,
  output logic               rd_valid,
  output logic [FRAME_W-1:0] rd_data
);
  logic [BX_W-1:0]    bx;
  logic               we, re;
  logic [AW-1:0]      waddr, raddr;
  logic [HDR_W-1:0]   hdr;
  logic [FRAME_W-1:0] wframe;

  hfs_bx_counter #(.W(BX_W)) u_bx (
    .clk(clk), .rst(rst), .bx(bx)
  );

  hfs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .trig(trig), .rd_en(rd_en),
    .we(we), .waddr(waddr), .re(re), .raddr(raddr),
    .cnt_q(frame_cnt), .full_q(ram_full), .rd_valid_q(rd_valid)
  );

  // header carries the slot index, padded or cut to the header width
  generate
    if (HDR_W > AW) begin : g_hdr_pad
      assign hdr = {{(HDR_W - AW){1'b0}}, waddr};
    end else begin : g_hdr_cut
      assign hdr = waddr[HDR_W-1:0];
    end
  endgenerate

  assign wframe = {hdr, bx, disc};

  hfs_frame_ram #(.W(FRAME_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wframe),
    .re(re), .raddr(raddr), .rdata(rd_data)
  );

  // R1: store is empty and idle right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (frame_cnt == '0 && !ram_full && !rd_valid));
  // R4: full flag agrees with the count
  a_r4_full_means_max: assert property (@(posedge clk) disable iff (rst)
    ram_full |-> frame_cnt == CW'(DEPTH));
endmodule

// File: tb/sim_hit_frame_store.sv
module sim_hit_frame_store;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst, trig, rd_en;
  logic [127:0] disc;
  logic [7:0]   frame_cnt;
  logic         ram_full, rd_valid;
  logic [159:0] rd_data;

  hit_frame_store u0 (
    .clk(clk), .rst(rst), .trig(trig), .disc(disc), .rd_en(rd_en),
    .frame_cnt(frame_cnt), .ram_full(ram_full), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // small instance: 2 channels, 3-bit crossing counter, 16 slots
  logic        trig1, rd1, full1, valid1;
  logic [4:0]  cnt1;
  logic [14:0] data1;
  hit_frame_store #(.NCH(2), .CODE_W(2), .BX_W(3), .HDR_W(8), .DEPTH(16)) u1 (
    .clk(clk), .rst(rst), .trig(trig1), .disc(4'h9), .rd_en(rd1),
    .frame_cnt(cnt1), .ram_full(full1), .rd_valid(valid1), .rd_data(data1)
  );

  int total = 0, bad = 0;

  task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [159:0] mq[$];
  int           mrp = 0;
  logic         mfull = 1'b0, mvalid = 1'b0;
  logic [159:0] mdata = '0;
  logic [23:0]  mbx = '0;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); mrp = 0; mfull = 1'b0; mvalid = 1'b0; mbx = '0;
    end else begin
      bit rdt, wrt;
      rdt = rd_en && (mq.size() != 0);
      wrt = trig && !mfull && (mrp == 0) && !rdt;
      mvalid = rdt;
      if (rdt) mdata = mq[mrp];
      if (wrt) begin
        mq.push_back({8'(mq.size()), mbx, disc});
        if (mq.size() == 128) mfull = 1'b1;
      end
      if (rdt) begin
        mrp++;
        if (mrp == mq.size()) begin mq.delete(); mrp = 0; mfull = 1'b0; end
      end
      mbx = mbx + 24'd1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 count", 160'(frame_cnt), 160'(mq.size()));
      chk("R4 full", 160'(ram_full), 160'(mfull));
      chk("R6 valid", 160'(rd_valid), 160'(mvalid));
      if (mvalid) chk("R2 frame data", rd_data, mdata);
    end
  end

  logic [14:0] cap[$];
  always @(negedge clk) if (!rst && valid1) cap.push_back(data1);

  task automatic step(input int n); repeat (n) @(negedge clk); endtask

  initial begin
    rst = 1'b1; trig = 1'b0; rd_en = 1'b0; disc = '0; trig1 = 1'b0; rd1 = 1'b0;
    step(4);
    chk("R1 count", 160'(frame_cnt), 160'd0);
    chk("R1 full", 160'(ram_full), 160'd0);
    chk("R1 valid", 160'(rd_valid), 160'd0);
    rst = 1'b0;
    step(1);
    chk("R1 count after release", 160'(frame_cnt), 160'd0);
    // five frames on consecutive cycles, distinct patterns
    trig = 1'b1; disc = '0;               step(1);
    disc = '1;                            step(1);
    disc = {64{2'b01}};                   step(1);
    disc = {64{2'b10}};                   step(1);
    disc = {$urandom, $urandom, $urandom, $urandom}; step(1);
    trig = 1'b0;
    chk("R3 five frames", 160'(frame_cnt), 160'd5);
    rd_en = 1'b1; step(1);
    rd_en = 1'b0; trig = 1'b1; disc = '1;
    chk("R2 header slot 0", 160'(rd_data[159:152]), 160'd0);
    chk("R3 all-zero frame kept", 160'(rd_data[127:0]), 160'd0);
    step(1);
    trig = 1'b0;
    chk("R8 trigger in readout ignored", 160'(frame_cnt), 160'd5);
    rd_en = 1'b1; step(4);
    rd_en = 1'b0;
    chk("R7 cleared after last read", 160'(frame_cnt), 160'd0);
    rd_en = 1'b1; step(1);
    rd_en = 1'b0; step(1);
    chk("R6 empty read ignored", 160'(rd_valid), 160'd0);
    // trigger and read in the same cycle
    trig = 1'b1; disc = {32{4'b0110}}; step(2);
    rd_en = 1'b1; step(1);
    trig = 1'b0; rd_en = 1'b0;
    chk("R8 read wins over trigger", 160'(frame_cnt), 160'd2);
    rd_en = 1'b1; step(1);
    rd_en = 1'b0;
    chk("R7 cleared", 160'(frame_cnt), 160'd0);
    // fill past capacity
    trig = 1'b1;
    for (int i = 0; i < 138; i++) begin
      disc = {$urandom, $urandom, $urandom, $urandom};
      step(1);
    end
    trig = 1'b0;
    chk("R4 full flag", 160'(ram_full), 160'd1);
    chk("R4 count capped", 160'(frame_cnt), 160'd128);
    rd_en = 1'b1; step(128);
    rd_en = 1'b0;
    chk("R7 count zero", 160'(frame_cnt), 160'd0);
    chk("R7 full cleared", 160'(ram_full), 160'd0);
    trig = 1'b1; disc = {64{2'b11}}; step(1);
    trig = 1'b0; rd_en = 1'b1; step(1);
    rd_en = 1'b0;
    chk("R7 restart at slot 0", 160'(rd_data[159:152]), 160'd0);
    // crossing-counter wrap on the small instance
    trig1 = 1'b1; step(12);
    trig1 = 1'b0;
    chk("R3 small count", 160'(cnt1), 160'd12);
    rd1 = 1'b1; step(12);
    rd1 = 1'b0; step(1);
    chk("R9 frames read", 160'(cap.size()), 160'd12);
    if (cap.size() == 12) begin
      for (int k = 1; k < 12; k++) begin
        chk("R9 crossing step", 160'(cap[k][6:4]), 160'(3'(cap[0][6:4] + k)));
        chk("R2 small header", 160'(cap[k][14:7]), 160'(k));
      end
      chk("R3 small codes", 160'(cap[3][3:0]), 160'h9);
    end
    step(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=run still going expected=finished before 20000 cycles");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule